// File: doc/BRIEF.md
# Watchdog Control and Status Logic

This block is a watchdog timer with a small control and status register. Once armed, it counts a software-programmed interval. When the interval runs out, the block sets an expiry flag and can raise an interrupt. It then counts a fixed grace period. If software has not restarted the timer by the end of that period and the reset enable is set, the block issues a one-clock system reset request.

Software uses a simple register port to arm the timer, restart it, clear or force the flag, and program the interval. Two reset inputs are kept apart. The power-on/power-fail reset clears every bit and sets the power-on flag. The general reset leaves the interrupt enable and the power-on flag alone. The timer is stopped only while both enables are clear. Setting the interrupt enable from that stopped state starts a fresh interval.

Top module: `wdt_ctrl`

## Requirements
- R1: After the power-on reset (`por_n` low), the control register (address 0) reads 0x10: only the power-on flag (bit 4) is set. The interval register (address 1) reads the parameter `DEF_INTERVAL`, and `irq` and `rst_req` are 0.
- R2: After a restart, the expiry flag (control bit 3) becomes 1 exactly N clocks later, where N is the interval register value. A value of 0 behaves as 1.
- R3: `irq` equals the expiry flag ANDed with the interrupt enable (control bit 1), whatever set the flag.
- R4: With the reset enable (control bit 2) at 1, `rst_req` is high for exactly one clock, `DLY_CYCLES` (512) clocks after the flag is set by expiry. With the reset enable at 0, `rst_req` stays 0.
- R5: While the interrupt enable and the reset enable are both 0, the timer does not advance and the flag is not set by expiry.
- R6: A control write that sets the interrupt enable while both enables are 0 restarts the interval from zero.
- R7: A control write with the restart bit (bit 0) set clears both counters. All other bits of that write are ignored, and the restart bit reads as 0.
- R8: A control write with the restart bit clear loads the flag from bit 3. Writing 0 clears the flag and writing 1 sets it.
- R9: A general reset (`rst_n` low) clears the reset enable, the flag, the counters and the interval (back to `DEF_INTERVAL`). It leaves the interrupt enable and the power-on flag unchanged.
- R10: The power-on flag is set only by the power-on reset. Writing 0 clears it, and writing 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on / power-fail reset, asynchronous, active low |
| rst_n | input | 1 | General reset, asynchronous, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address (0 control, 1 interval) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data for `rd_addr`, combinational |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | One-clock system reset request |

## Verification
The bench measures expiry to the exact clock. An off-by-one terminal compare would show up as a flag one cycle early or late. It also stops the timer partway through an interval and then re-arms it through the interrupt enable. A design that resumed the old count instead of restarting would set the flag several clocks too early. A restart write carries all-zero enable bits, which exposes a design that treats that write as an ordinary register load. Pulsing the general reset catches a design that wrongly clears the interrupt enable or the power-on flag. A table entry with interval 0 catches an underflowing compare, which would wait about 65536 clocks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // control register bit positions
   localparam int unsigned BIT_RESTART = 0;
   localparam int unsigned BIT_IE      = 1;
   localparam int unsigned BIT_RE      = 2;
   localparam int unsigned BIT_FLAG    = 3;
   localparam int unsigned BIT_POF     = 4;
   localparam int unsigned CTRL_BITS   = 5;

   typedef enum logic {
      PH_COUNT = 1'b0,
      PH_DELAY = 1'b1
   } wdt_phase_e;

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned ADDR_W       = 2,
   parameter int unsigned INTERVAL_W   = 16,
   parameter int unsigned DEF_INTERVAL = 1000
) (
   input  logic                  clk,
   input  logic                  por_n,
   input  logic                  rst_n,
   input  logic                  any_rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic [ADDR_W-1:0]     rd_addr,
   input  logic                  expire,
   output logic [DATA_W-1:0]     rd_data,
   output logic                  ie,
   output logic                  re,
   output logic                  flag,
   output logic                  pof,
   output logic [INTERVAL_W-1:0] interval,
   output logic                  cnt_clr
);

   localparam logic [ADDR_W-1:0]     CTRL_ADDR = '0;
   localparam logic [ADDR_W-1:0]     INTV_ADDR = ADDR_W'(1);
   localparam logic [INTERVAL_W-1:0] INTV_RST  = INTERVAL_W'(DEF_INTERVAL);

   logic ctrl_wr, intv_wr, restart_wr, cfg_wr, halted;

   // writes are dropped while the general reset is held
   assign ctrl_wr    = wr_en & rst_n & (wr_addr == CTRL_ADDR);
   assign intv_wr    = wr_en & rst_n & (wr_addr == INTV_ADDR);
   assign restart_wr = ctrl_wr &  wr_data[BIT_RESTART];
   assign cfg_wr     = ctrl_wr & ~wr_data[BIT_RESTART];
   assign halted     = ~ie & ~re;
   assign cnt_clr    = restart_wr | (cfg_wr & halted & wr_data[BIT_IE]);

   // interrupt enable: power-on reset only
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      ie <= 1'b0;
      else if (cfg_wr) ie <= wr_data[BIT_IE];
   end

   // power-on flag: set by power-on reset, cleared by software only
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                           pof <= 1'b1;
      else if (cfg_wr && !wr_data[BIT_POF]) pof <= 1'b0;
   end

   always_ff @(posedge clk or negedge any_rst_n) begin
      if (!any_rst_n)  re <= 1'b0;
      else if (cfg_wr) re <= wr_data[BIT_RE];
   end

   // hardware expiry takes precedence over a software clear
   always_ff @(posedge clk or negedge any_rst_n) begin
      if (!any_rst_n)  flag <= 1'b0;
      else if (expire) flag <= 1'b1;
      else if (cfg_wr) flag <= wr_data[BIT_FLAG];
   end

   always_ff @(posedge clk or negedge any_rst_n) begin
      if (!any_rst_n)   interval <= INTV_RST;
      else if (intv_wr) interval <= wr_data[INTERVAL_W-1:0];
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == CTRL_ADDR) begin
         rd_data[BIT_IE]   = ie;
         rd_data[BIT_RE]   = re;
         rd_data[BIT_FLAG] = flag;
         rd_data[BIT_POF]  = pof;
      end else if (rd_addr == INTV_ADDR) begin
         rd_data[INTERVAL_W-1:0] = interval;
      end
   end

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
   import wdt_pkg::*;
#(
   parameter int unsigned INTERVAL_W = 16,
   parameter int unsigned DLY_CYCLES = 512
) (
   input  logic                  clk,
   input  logic                  any_rst_n,
   input  logic                  run,
   input  logic                  clr,
   input  logic                  re,
   input  logic [INTERVAL_W-1:0] interval,
   output logic                  expire,
   output logic                  rst_req
);

   localparam int unsigned   DLY_W    = $clog2(DLY_CYCLES);
   localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(DLY_CYCLES - 1);

   logic [INTERVAL_W-1:0] cnt_q;
   logic [DLY_W-1:0]      dly_q;
   wdt_phase_e            phase_q;
   logic [INTERVAL_W:0]   cnt_nxt;
   logic                  terminal, dly_done;

   // zero interval acts as one: compare count+1 against the interval
   assign cnt_nxt  = {1'b0, cnt_q} + (INTERVAL_W+1)'(1);
   assign terminal = cnt_nxt >= {1'b0, interval};
   assign expire   = run & ~clr & (phase_q == PH_COUNT) & terminal;
   assign dly_done = run & ~clr & (phase_q == PH_DELAY) & (dly_q == DLY_LAST);

   always_ff @(posedge clk or negedge any_rst_n) begin
      if (!any_rst_n) begin
         cnt_q   <= '0;
         dly_q   <= '0;
         phase_q <= PH_COUNT;
         rst_req <= 1'b0;
      end else begin
         rst_req <= dly_done & re;
         if (clr) begin
            cnt_q   <= '0;
            dly_q   <= '0;
            phase_q <= PH_COUNT;
         end else if (run) begin
            if (phase_q == PH_COUNT) begin
               if (terminal) begin
                  cnt_q   <= '0;
                  dly_q   <= '0;
                  phase_q <= PH_DELAY;
               end else begin
                  cnt_q <= cnt_q + INTERVAL_W'(1);
               end
            end else begin
               if (dly_q == DLY_LAST) begin
                  dly_q   <= '0;
                  phase_q <= PH_COUNT;
               end else begin
                  dly_q <= dly_q + DLY_W'(1);
               end
            end
         end
      end
   end

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
   import wdt_pkg::*;
#(
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned ADDR_W       = 2,
   parameter int unsigned INTERVAL_W   = 16,
   parameter int unsigned DEF_INTERVAL = 1000,
   parameter int unsigned DLY_CYCLES   = 512,
   parameter bit          IRQ_REG      = 1'b0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq,
   output logic              rst_req
);

   // elaboration-time parameter checks
   if (INTERVAL_W < 1 || DATA_W < INTERVAL_W) begin : g_bad_width
      $error("wdt_ctrl: INTERVAL_W must be 1..DATA_W");
   end
   if (DATA_W < CTRL_BITS) begin : g_bad_data
      $error("wdt_ctrl: DATA_W too narrow for control fields");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("wdt_ctrl: ADDR_W must be at least 1");
   end
   if (DLY_CYCLES < 2) begin : g_bad_dly
      $error("wdt_ctrl: DLY_CYCLES must be at least 2");
   end

   logic                  any_rst_n;
   logic                  ie_q, re_q, flag_q, pof_q, cnt_clr, expire;
   logic [INTERVAL_W-1:0] interval_q;

   assign any_rst_n = por_n & rst_n;

   wdt_regs #(
      .DATA_W      (DATA_W),
      .ADDR_W      (ADDR_W),
      .INTERVAL_W  (INTERVAL_W),
      .DEF_INTERVAL(DEF_INTERVAL)
   ) u_regs (
      .clk      (clk),
      .por_n    (por_n),
      .rst_n    (rst_n),
      .any_rst_n(any_rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .expire   (expire),
      .rd_data  (rd_data),
      .ie       (ie_q),
      .re       (re_q),
      .flag     (flag_q),
      .pof      (pof_q),
      .interval (interval_q),
      .cnt_clr  (cnt_clr)
   );

   wdt_timer #(
      .INTERVAL_W(INTERVAL_W),
      .DLY_CYCLES(DLY_CYCLES)
   ) u_timer (
      .clk      (clk),
      .any_rst_n(any_rst_n),
      .run      (ie_q | re_q),
      .clr      (cnt_clr),
      .re       (re_q),
      .interval (interval_q),
      .expire   (expire),
      .rst_req  (rst_req)
   );

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge any_rst_n) begin
         if (!any_rst_n) irq <= 1'b0;
         else            irq <= flag_q & ie_q;
      end
   end else begin : g_irq_comb
      assign irq = flag_q & ie_q;
   end

endmodule

// File: rtl/wdt_ctrl_chk.sv
module wdt_ctrl_chk #(
   parameter bit IRQ_REG = 1'b0
) (
   input logic clk,
   input logic por_n,
   input logic rst_n,
   input logic ie,
   input logic re,
   input logic flag,
   input logic pof,
   input logic expire,
   input logic irq,
   input logic rst_req
);

   // R4
   rst_one_clk_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      rst_req |=> !rst_req);

   // R4
   rst_needs_re_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      rst_req |-> $past(re));

   // R2
   expire_sets_flag_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      expire |=> flag);

   // R5
   halted_no_expire_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      (!ie && !re) |-> !expire);

   // R9
   ie_keeps_on_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
      !rst_n |=> $stable(ie));

   // R10
   pof_no_rise_chk: assert property (@(posedge clk) disable iff (!por_n)
      !$rose(pof));

   if (IRQ_REG) begin : g_reg
      // R3
      irq_gate_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
         irq |-> $past(flag && ie));
   end else begin : g_comb
      // R3
      irq_gate_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
         irq |-> (flag && ie));
   end

endmodule

bind wdt_ctrl wdt_ctrl_chk #(.IRQ_REG(IRQ_REG)) u_chk (
   .clk    (clk),
   .por_n  (por_n),
   .rst_n  (rst_n),
   .ie     (ie_q),
   .re     (re_q),
   .flag   (flag_q),
   .pof    (pof_q),
   .expire (expire),
   .irq    (irq),
   .rst_req(rst_req)
);

// File: tb/wdt_ctrl_tb.sv
`timescale 1ns/1ps
module wdt_ctrl_tb;

   localparam int DATA_W = 16;
   localparam int ADDR_W = 2;
   localparam int DEF    = 1000;
   localparam int DLY    = 512;

   localparam logic [15:0] RESTART = 16'h01;
   localparam logic [15:0] IE      = 16'h02;
   localparam logic [15:0] RE      = 16'h04;
   localparam logic [15:0] FLAG    = 16'h08;
   localparam logic [15:0] POF     = 16'h10;

   // {interval, ie, re, exp_flag, exp_irq, exp_rst}
   typedef struct packed {
      logic [15:0] n;
      logic        ie;
      logic        re;
      logic        e_flag;
      logic        e_irq;
      logic        e_rst;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{16'd5,   1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
      '{16'd20,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
      '{16'd1,   1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
      '{16'd300, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
      '{16'd8,   1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{16'd0,   1'b1, 1'b1, 1'b1, 1'b1, 1'b1}
   };

   logic              clk = 1'b0;
   logic              por_n, rst_n, wr_en;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic [DATA_W-1:0] wr_data, rd_data;
   logic              irq, rst_req;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   wdt_ctrl #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .INTERVAL_W(16),
      .DEF_INTERVAL(DEF), .DLY_CYCLES(DLY), .IRQ_REG(1'b0)
   ) u_dut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .irq(irq), .rst_req(rst_req)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic adv(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(logic [ADDR_W-1:0] a, logic [15:0] d);
      wr_addr = a;
      wr_data = d;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic rd(logic [ADDR_W-1:0] a, output logic [15:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
      rd_addr = '0;
   endtask

   function automatic logic flag_now();
      return rd_data[3];
   endfunction

   initial begin
      logic [15:0] v;
      por_n = 1'b1; rst_n = 1'b1; wr_en = 1'b0;
      wr_addr = '0; wr_data = '0; rd_addr = '0;
      #1 por_n = 1'b0;
      adv(3);
      por_n = 1'b1;
      adv(1);

      // R1 reset state
      rd(0, v); check("R1 ctrl", v, 16'h10);
      rd(1, v); check("R1 interval", v, DEF);
      check("R1 irq", irq, 0);
      check("R1 rst_req", rst_req, 0);

      // R10 power-on flag write behaviour
      wr(0, POF);  rd(0, v); check("R10 write1 keeps", v, 16'h10);
      wr(0, 16'h0); rd(0, v); check("R10 write0 clears", v, 16'h00);
      wr(0, POF);  rd(0, v); check("R10 write1 no set", v, 16'h00);

      // table walk: R2 R3 R4 R5
      foreach (VECS[k]) begin
         vec_t t = VECS[k];
         int nn = (t.n == 0) ? 1 : int'(t.n);
         wr(0, 16'h0);
         wr(1, t.n);
         wr(0, (t.ie ? IE : 16'h0) | (t.re ? RE : 16'h0));
         wr(0, RESTART);
         adv(nn - 1);
         check($sformatf("R2 vec%0d flag early", k), flag_now(), 0);
         check($sformatf("R3 vec%0d irq early", k), irq, 0);
         adv(1);
         check($sformatf("R2 R5 vec%0d flag", k), flag_now(), t.e_flag);
         check($sformatf("R3 vec%0d irq", k), irq, t.e_irq);
         adv(DLY - 1);
         check($sformatf("R4 vec%0d rst early", k), rst_req, 0);
         adv(1);
         check($sformatf("R4 vec%0d rst", k), rst_req, t.e_rst);
         adv(1);
         check($sformatf("R4 vec%0d rst one clk", k), rst_req, 0);
      end

      // R6 re-arm from halted restarts the interval
      wr(0, 16'h0);
      wr(1, 16'd10);
      wr(0, IE);
      adv(6);
      wr(0, 16'h0);
      adv(20);
      check("R5 halted no flag", flag_now(), 0);
      wr(0, IE);
      adv(9);
      check("R6 flag not early", flag_now(), 0);
      adv(1);
      check("R6 flag at interval", flag_now(), 1);

      // R7 restart bit ignores other fields
      wr(0, RESTART);
      rd(0, v); check("R7 fields kept", v, 16'h0A);
      wr(0, IE);
      adv(4);
      wr(0, RESTART);
      adv(9);
      check("R7 flag not early", flag_now(), 0);
      adv(1);
      check("R7 flag after restart", flag_now(), 1);

      // R8 R3 software flag control (delay phase active, no expiry)
      wr(0, IE);
      check("R8 clear", flag_now(), 0);
      check("R3 irq after clear", irq, 0);
      wr(0, IE | FLAG);
      check("R8 set", flag_now(), 1);
      check("R3 irq from sw flag", irq, 1);
      wr(0, FLAG);
      check("R3 irq masked", irq, 0);
      check("R8 flag kept", flag_now(), 1);
      wr(0, 16'h0);

      // R9 general reset
      wr(0, IE | RE | FLAG);
      wr(1, 16'd50);
      rst_n = 1'b0;
      adv(2);
      rst_n = 1'b1;
      adv(1);
      rd(0, v); check("R9 ctrl after rst_n", v, 16'h02);
      rd(1, v); check("R9 interval default", v, DEF);
      check("R9 rst_req", rst_req, 0);

      // R10 R1 power-on reset again
      por_n = 1'b0;
      adv(2);
      por_n = 1'b1;
      adv(1);
      rd(0, v); check("R10 R1 ctrl after por", v, 16'h10);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog timeout (all requirements) actual=running expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule